// File: doc/BRIEF.md
# Register-Access Request Sequencer

This block sits on the host side of a command mailbox. A client hands it one request: read, write or read-modify-write of a short list of byte-wide registers, each named by a 16-bit address. The sequencer turns that request into a single mailbox transaction. It packs the addresses and any data bytes into the mailbox write buffer as 32-bit words, then writes the command word. It polls the mailbox status until the busy flag drops or a fixed poll budget runs out. For reads, it fetches the read buffer and extracts one byte per item.

Two payload layouts can be chosen per request. In the interleaved layout each item's address is followed directly by its data. In the split layout all addresses come first and the data follows them. The two layouts also take read results from different offsets. Only one transaction is in flight at a time: the request side stays not-ready from acceptance until the response has been delivered.

Top module: `regacc_seq`

## Requirements
- R1: Operation codes are 0 write, 1 read, 2 read-modify-write. A request is refused when any of the following holds: the count is 0, the count is above MAX_ITEMS (5), the operation code is 3, or the request is a split-layout read-modify-write with a count other than 1. A refused request is answered with result code 3 in the cycle after acceptance and makes no mailbox access.
- R2: In the interleaved layout, item i starts at byte i*S, where S is 2 for read, 3 for write and 4 for read-modify-write. The item holds address bits 7:0, then address bits 15:8. A write then adds data byte i; a read-modify-write adds value byte 2i and then mask byte 2i+1. The size is S times the count.
- R3: In the split layout, address i occupies bytes 2i (low) and 2i+1 (high). Write data byte i goes to byte 2*count+i. The size is 2*count for a read and 3*count for a write. A read-modify-write is one item of size 4: address low, address high, value, mask.
- R4: The payload is written as ceil(size/4) words in ascending order. Word w goes to offset 0x80+4w, and byte k lies in bits 8*(k%4)+7:8*(k%4) of word k/4. Unused bytes of the last word are zero. No other write-buffer word is written, and every payload write comes before the command write.
- R5: Exactly one command word is written, at offset 0x00. Its value is size<<16 | op<<12 | 0xFF, and every other bit is zero, including the completion-interrupt bit 8.
- R6: After the command, status is read at offset 0x04; bit 0 is busy and bit 1 is error. Successive status reads are POLL_GAP+2 cycles apart.
- R7: If POLL_LIMIT+1 status reads in a row all show busy, the result is code 1 (timeout). No further status read is made and the read buffer is not touched.
- R8: If busy is clear on the last permitted status read, the transaction completes normally rather than timing out.
- R9: When busy is clear, status bit 1 set gives code 2 (device error) and bit 1 clear gives code 0 (ok). Bit 1 is ignored while busy is set.
- R10: A read that ends ok fetches the four read-buffer words at offsets 0x90 to 0x9C. Response byte n (bits 8n+7:8n) is read-buffer byte 2+3n in the interleaved layout and byte n in the split layout, for n below the count; higher bytes are zero. Every other response carries zero data, and no other transaction reads the read buffer.
- R11: req_ready is low from the cycle after acceptance until rsp_valid has been high for one cycle. rsp_valid is a one-cycle pulse. Request fields presented while not ready are ignored.
- R12: After reset, req_ready is high, rsp_valid is low and no mailbox access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_op | input | 2 | Operation code |
| req_split | input | 1 | 1 selects the split layout |
| req_count | input | 3 | Number of items |
| req_addr | input | 80 | Item i address in bits 16i+15:16i |
| req_data | input | 80 | Data byte j in bits 8j+7:8j |
| rsp_valid | output | 1 | Response pulse |
| rsp_code | output | 2 | 0 ok, 1 timeout, 2 device error, 3 refused |
| rsp_data | output | 40 | Read result byte n in bits 8n+7:8n |
| mb_wr | output | 1 | Mailbox register write strobe |
| mb_rd | output | 1 | Mailbox register read strobe |
| mb_addr | output | 8 | Mailbox byte offset |
| mb_wdata | output | 32 | Mailbox write data |
| mb_rdata | input | 32 | Mailbox read data, valid the cycle after mb_rd |

## Verification
Two events can land on the same status read: the poll budget running out and busy clearing. The bench sets up that coincidence by letting busy drop exactly on read POLL_LIMIT+1. The outcome must then be ok, or device error when bit 1 is set, with exactly POLL_LIMIT+1 status reads counted. In the companion case busy stays set one read longer, and the outcome must be a timeout even though the error bit is set throughout. A second overlap comes from holding req_valid high, with changing fields, across the whole transaction and through the response cycle. That stimulus must produce exactly one acceptance and a response computed from the original fields.

// File: rtl/regacc_pkg.sv
package regacc_pkg;

  localparam logic [1:0] OP_WRITE = 2'd0;
  localparam logic [1:0] OP_READ  = 2'd1;
  localparam logic [1:0] OP_RMW   = 2'd2;

  typedef enum logic [1:0] {
    RC_OK      = 2'd0,
    RC_TIMEOUT = 2'd1,
    RC_DEVERR  = 2'd2,
    RC_BADREQ  = 2'd3
  } rsp_code_e;

  typedef enum logic [3:0] {
    S_IDLE, S_WBUF, S_CMD, S_POLL, S_PWAIT, S_GAP, S_RBUF, S_RWAIT, S_RESP
  } seq_state_e;

  // bytes occupied by one item in the interleaved layout
  function automatic int item_stride(input logic [1:0] op);
    case (op)
      OP_READ:  return 2;
      OP_WRITE: return 3;
      default:  return 4;
    endcase
  endfunction

  function automatic int packed_size(input logic [1:0] op, input int count,
                                     input logic split);
    if (split && op == OP_RMW) return 4;
    return count * item_stride(op);
  endfunction

  function automatic logic request_ok(input logic [1:0] op, input int count,
                                      input logic split, input int max_items);
    if (count < 1 || count > max_items) return 1'b0;
    if (op == 2'd3) return 1'b0;
    if (split && op == OP_RMW && count != 1) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int resp_offset(input logic split, input int n);
    return split ? n : 2 + 3 * n;
  endfunction

  function automatic int words_for(input int nbytes);
    return (nbytes + 3) / 4;
  endfunction

endpackage

// File: rtl/regacc_packer.sv
module regacc_packer
  import regacc_pkg::*;
#(
  parameter int MAX_ITEMS = 5,
  localparam int CNT_W = $clog2(MAX_ITEMS + 1),
  localparam int WBUF_BYTES = 4 * MAX_ITEMS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                op,
  input  logic                      split,
  input  logic [CNT_W-1:0]          count,
  input  logic [MAX_ITEMS*16-1:0]   addr,
  input  logic [MAX_ITEMS*16-1:0]   data,
  output logic [WBUF_BYTES*8-1:0]   pbytes,
  output logic [7:0]                psize,
  output logic                      legal
);

  always_comb begin
    pbytes = '0;
    for (int i = 0; i < MAX_ITEMS; i++) begin
      if (i < int'(count)) begin
        if (split) begin
          pbytes[(2*i)*8 +: 8]   = addr[i*16 +: 8];
          pbytes[(2*i+1)*8 +: 8] = addr[i*16+8 +: 8];
          if (op == OP_WRITE)
            pbytes[(2*int'(count)+i)*8 +: 8] = data[i*8 +: 8];
        end else begin
          pbytes[(i*item_stride(op))*8 +: 8]   = addr[i*16 +: 8];
          pbytes[(i*item_stride(op)+1)*8 +: 8] = addr[i*16+8 +: 8];
          if (op == OP_WRITE)
            pbytes[(i*3+2)*8 +: 8] = data[i*8 +: 8];
          else if (op == OP_RMW) begin
            pbytes[(i*4+2)*8 +: 8] = data[(2*i)*8 +: 8];
            pbytes[(i*4+3)*8 +: 8] = data[(2*i+1)*8 +: 8];
          end
        end
      end
    end
    if (split && op == OP_RMW) begin
      pbytes[2*8 +: 8] = data[0 +: 8];
      pbytes[3*8 +: 8] = data[8 +: 8];
    end
  end

  assign psize = 8'(packed_size(op, int'(count), split));
  assign legal = request_ok(op, int'(count), split, MAX_ITEMS);

  // R2: a legal request always fits the write buffer
  a_r2_size_fits: assert property (@(posedge clk) disable iff (!rst_n)
    legal |-> (psize <= 8'(WBUF_BYTES) && psize >= 8'd2));
  // R3: split read-modify-write is a single four-byte item
  a_r3_split_rmw_four: assert property (@(posedge clk) disable iff (!rst_n)
    (legal && split && op == OP_RMW) |-> psize == 8'd4);

endmodule

// File: rtl/regacc_unpacker.sv
module regacc_unpacker
  import regacc_pkg::*;
#(
  parameter int MAX_ITEMS = 5,
  parameter int RBUF_BYTES = 16,
  localparam int CNT_W = $clog2(MAX_ITEMS + 1)
) (
  input  logic [RBUF_BYTES*8-1:0] rbuf,
  input  logic                    split,
  input  logic [CNT_W-1:0]        count,
  output logic [MAX_ITEMS*8-1:0]  rbytes
);

  always_comb begin
    rbytes = '0;
    for (int n = 0; n < MAX_ITEMS; n++)
      if (n < int'(count))
        rbytes[n*8 +: 8] = rbuf[resp_offset(split, n)*8 +: 8];
  end

endmodule

// File: rtl/regacc_poll_timer.sv
module regacc_poll_timer #(
  parameter int POLL_LIMIT = 100000,
  parameter int POLL_GAP = 100,
  localparam int BW = $clog2(POLL_LIMIT + 1) + 1,
  localparam int GW = $clog2(POLL_GAP + 1) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic busy_seen,
  input  logic gap_active,
  output logic last_poll,
  output logic gap_done
);

  logic [BW-1:0] busy_cnt;
  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_cnt <= '0;
    else if (clear)     busy_cnt <= '0;
    else if (busy_seen) busy_cnt <= busy_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gap_cnt <= '0;
    else if (gap_active) gap_cnt <= gap_cnt + 1'b1;
    else                 gap_cnt <= '0;
  end

  assign last_poll = (busy_cnt == BW'(POLL_LIMIT));
  assign gap_done  = gap_active && (gap_cnt == GW'(POLL_GAP - 1));

  // R7: busy observations never run past the budget
  a_r7_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= BW'(POLL_LIMIT));
  // R6: the wait between polls never overruns its length
  a_r6_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    gap_active |-> gap_cnt < GW'(POLL_GAP));

endmodule

// File: rtl/regacc_seq.sv
module regacc_seq
  import regacc_pkg::*;
#(
  parameter int MAX_ITEMS = 5,
  parameter int POLL_LIMIT = 100000,
  parameter int POLL_GAP = 100,
  parameter int ADDR_W = 8,
  parameter int RBUF_BYTES = 16,
  parameter logic [7:0] MSG_TYPE = 8'hFF,
  parameter logic [7:0] CMD_OFF = 8'h00,
  parameter logic [7:0] STAT_OFF = 8'h04,
  parameter logic [7:0] WBUF_OFF = 8'h80,
  parameter logic [7:0] RBUF_OFF = 8'h90,
  localparam int CNT_W = $clog2(MAX_ITEMS + 1),
  localparam int WBUF_BYTES = 4 * MAX_ITEMS,
  localparam int WBUF_WORDS = MAX_ITEMS,
  localparam int WIDX_W = $clog2(WBUF_WORDS + 1),
  localparam int RBUF_WORDS = RBUF_BYTES / 4,
  localparam int RIDX_W = $clog2(RBUF_WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [1:0]              req_op,
  input  logic                    req_split,
  input  logic [CNT_W-1:0]        req_count,
  input  logic [MAX_ITEMS*16-1:0] req_addr,
  input  logic [MAX_ITEMS*16-1:0] req_data,
  output logic                    rsp_valid,
  output logic [1:0]              rsp_code,
  output logic [MAX_ITEMS*8-1:0]  rsp_data,
  output logic                    mb_wr,
  output logic                    mb_rd,
  output logic [ADDR_W-1:0]       mb_addr,
  output logic [31:0]             mb_wdata,
  input  logic [31:0]             mb_rdata
);

  seq_state_e              state;
  logic [1:0]              op_q;
  logic                    split_q;
  logic [CNT_W-1:0]        cnt_q;
  logic [WBUF_BYTES*8-1:0] wbuf_q;
  logic [7:0]              size_q;
  logic [WIDX_W-1:0]       nwords_q;
  logic [WIDX_W-1:0]       widx;
  logic [RIDX_W-1:0]       ridx;
  logic [RBUF_BYTES*8-1:0] rbuf_q;
  rsp_code_e               code_q;

  logic [WBUF_BYTES*8-1:0] pk_bytes;
  logic [7:0]              pk_size;
  logic                    req_legal;
  logic [MAX_ITEMS*8-1:0]  unp_bytes;
  logic                    tmr_last, tmr_gap_done;

  // named internal events
  logic evt_accept, evt_poll_busy, evt_poll_free, evt_wbuf_last, evt_rbuf_last;
  assign evt_accept    = req_valid && req_ready;
  assign evt_poll_busy = (state == S_PWAIT) && mb_rdata[0];
  assign evt_poll_free = (state == S_PWAIT) && !mb_rdata[0];
  assign evt_wbuf_last = (state == S_WBUF) && (widx == nwords_q - 1'b1);
  assign evt_rbuf_last = (state == S_RWAIT) && (ridx == RIDX_W'(RBUF_WORDS - 1));

  regacc_packer #(.MAX_ITEMS(MAX_ITEMS)) u_pack (
    .clk(clk), .rst_n(rst_n), .op(req_op), .split(req_split), .count(req_count),
    .addr(req_addr), .data(req_data), .pbytes(pk_bytes), .psize(pk_size),
    .legal(req_legal)
  );

  regacc_unpacker #(.MAX_ITEMS(MAX_ITEMS), .RBUF_BYTES(RBUF_BYTES)) u_unpack (
    .rbuf(rbuf_q), .split(split_q), .count(cnt_q), .rbytes(unp_bytes)
  );

  regacc_poll_timer #(.POLL_LIMIT(POLL_LIMIT), .POLL_GAP(POLL_GAP)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(state == S_CMD),
    .busy_seen(evt_poll_busy && !tmr_last), .gap_active(state == S_GAP),
    .last_poll(tmr_last), .gap_done(tmr_gap_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_q     <= '0;
      split_q  <= 1'b0;
      cnt_q    <= '0;
      wbuf_q   <= '0;
      size_q   <= '0;
      nwords_q <= '0;
      widx     <= '0;
      ridx     <= '0;
      rbuf_q   <= '0;
      code_q   <= RC_OK;
    end else begin
      case (state)
        S_IDLE: if (evt_accept) begin
          op_q     <= req_op;
          split_q  <= req_split;
          cnt_q    <= req_count;
          wbuf_q   <= pk_bytes;
          size_q   <= pk_size;
          nwords_q <= WIDX_W'(words_for(int'(pk_size)));
          widx     <= '0;
          ridx     <= '0;
          rbuf_q   <= '0;
          code_q   <= RC_OK;
          if (req_legal) state <= S_WBUF;
          else begin
            code_q <= RC_BADREQ;
            state  <= S_RESP;
          end
        end
        S_WBUF: begin
          widx <= widx + 1'b1;
          if (evt_wbuf_last) state <= S_CMD;
        end
        S_CMD:  state <= S_POLL;
        S_POLL: state <= S_PWAIT;
        S_PWAIT: begin
          if (evt_poll_busy) begin
            if (tmr_last) begin
              code_q <= RC_TIMEOUT;
              state  <= S_RESP;
            end else state <= S_GAP;
          end else if (mb_rdata[1]) begin
            code_q <= RC_DEVERR;
            state  <= S_RESP;
          end else begin
            code_q <= RC_OK;
            state  <= (op_q == OP_READ) ? S_RBUF : S_RESP;
          end
        end
        S_GAP:  if (tmr_gap_done) state <= S_POLL;
        S_RBUF: state <= S_RWAIT;
        S_RWAIT: begin
          rbuf_q[ridx*32 +: 32] <= mb_rdata;
          if (evt_rbuf_last) state <= S_RESP;
          else begin
            ridx  <= ridx + 1'b1;
            state <= S_RBUF;
          end
        end
        S_RESP: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mb_wr    = 1'b0;
    mb_rd    = 1'b0;
    mb_addr  = '0;
    mb_wdata = '0;
    case (state)
      S_WBUF: begin
        mb_wr    = 1'b1;
        mb_addr  = ADDR_W'(WBUF_OFF) + ADDR_W'({widx, 2'b00});
        mb_wdata = wbuf_q[widx*32 +: 32];
      end
      S_CMD: begin
        mb_wr    = 1'b1;
        mb_addr  = ADDR_W'(CMD_OFF);
        mb_wdata = {8'h00, size_q, 2'b00, op_q, 4'h0, MSG_TYPE};
      end
      S_POLL: begin
        mb_rd   = 1'b1;
        mb_addr = ADDR_W'(STAT_OFF);
      end
      S_RBUF: begin
        mb_rd   = 1'b1;
        mb_addr = ADDR_W'(RBUF_OFF) + ADDR_W'({ridx, 2'b00});
      end
      default: ;
    endcase
  end

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_RESP);
  assign rsp_code  = code_q;
  assign rsp_data  = (rsp_valid && code_q == RC_OK && op_q == OP_READ) ? unp_bytes : '0;

  // R11: one transaction outstanding
  a_r11_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> !req_ready);
  a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R1: refused request answers next cycle
  a_r1_refuse_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_accept && !req_legal) |=> (rsp_valid && rsp_code == 2'd3));
  // R4: never a read and a write together
  a_r4_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mb_wr && mb_rd));
  // R5: one command write per transaction
  a_r5_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_wr && mb_addr == ADDR_W'(CMD_OFF)) |=> !(mb_wr && mb_addr == ADDR_W'(CMD_OFF)));
  // R7: a timeout only once the budget is spent
  a_r7_timeout_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'd1) |-> tmr_last);
  // R10: non-ok responses carry no data
  a_r10_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != 2'd0) |-> rsp_data == '0);
  // R12: no bus traffic while idle
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(mb_wr || mb_rd));

endmodule

// File: tb/regacc_seq_test.sv
module regacc_seq_test;

  localparam int LIMIT = 4;
  localparam int GAP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic        req_split = 1'b0;
  logic [2:0]  req_count = '0;
  logic [79:0] req_addr = '0;
  logic [79:0] req_data = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [39:0] rsp_data;
  logic        mb_wr, mb_rd;
  logic [7:0]  mb_addr;
  logic [31:0] mb_wdata;
  logic [31:0] mb_rdata;

  always #5 clk = ~clk;

  regacc_seq #(.POLL_LIMIT(LIMIT), .POLL_GAP(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_split(req_split), .req_count(req_count),
    .req_addr(req_addr), .req_data(req_data), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .rsp_data(rsp_data), .mb_wr(mb_wr), .mb_rd(mb_rd),
    .mb_addr(mb_addr), .mb_wdata(mb_wdata), .mb_rdata(mb_rdata)
  );

  int checks = 0;
  int fails = 0;

  // mailbox model
  logic        model_clr = 1'b0;
  int          busy_n = 0;
  logic        err_bit = 1'b0;
  logic [7:0]  rb [16];
  logic [31:0] wimg [5];
  logic [31:0] cmd_word;
  int cmd_writes, buf_writes, wr_after_cmd, stat_reads, rb_reads, acc_cnt, cyc;
  int stamp [8];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (model_clr) begin
      for (int w = 0; w < 5; w++) wimg[w] <= 32'hA5A5_0000 | w;
      cmd_word <= '0; cmd_writes <= 0; buf_writes <= 0; wr_after_cmd <= 0;
      stat_reads <= 0; rb_reads <= 0; acc_cnt <= 0;
    end else begin
      if (req_valid && req_ready) acc_cnt <= acc_cnt + 1;
      if (mb_wr) begin
        if (mb_addr == 8'h00) begin
          cmd_word <= mb_wdata; cmd_writes <= cmd_writes + 1;
        end else if (mb_addr >= 8'h80 && mb_addr < 8'h94) begin
          wimg[(mb_addr - 8'h80) >> 2] <= mb_wdata;
          buf_writes <= buf_writes + 1;
          if (cmd_writes != 0) wr_after_cmd <= wr_after_cmd + 1;
        end
      end
      if (mb_rd) begin
        if (mb_addr == 8'h04) begin
          mb_rdata <= {30'b0, err_bit, stat_reads < busy_n};
          if (stat_reads < 8) stamp[stat_reads] <= cyc;
          stat_reads <= stat_reads + 1;
        end else if (mb_addr >= 8'h90 && mb_addr <= 8'h9C) begin
          mb_rdata <= {rb[mb_addr-8'h90+3], rb[mb_addr-8'h90+2],
                       rb[mb_addr-8'h90+1], rb[mb_addr-8'h90]};
          rb_reads <= rb_reads + 1;
        end else mb_rdata <= 32'hDEAD_BEEF;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  int unsigned seed = 32'h1234_5678;
  function automatic int unsigned nxt();
    seed = seed * 1103515245 + 12345;
    return seed >> 8;
  endfunction

  task automatic run(input logic [1:0] op, input int cnt, input logic sp,
                     input int bn, input logic eb_in);
    logic [15:0] ta [5];
    logic [7:0]  td [10];
    logic [7:0]  eb [20];
    int idx, d, size, nw, exp_code, exp_reads, viol;
    bit legal, got;
    logic [39:0] exp_data;
    logic [1:0] code_s;
    logic [39:0] data_s;
    for (int i = 0; i < 5; i++) ta[i] = 16'(nxt());
    for (int i = 0; i < 10; i++) td[i] = 8'(nxt());
    for (int i = 0; i < 16; i++) rb[i] = 8'(nxt());
    for (int i = 0; i < 20; i++) eb[i] = 8'h00;
    busy_n = bn; err_bit = eb_in;
    // expected packing, built with a running cursor
    idx = 0; d = 0;
    if (!sp) begin
      for (int i = 0; i < cnt && i < 5; i++) begin
        eb[idx] = ta[i][7:0]; eb[idx+1] = ta[i][15:8]; idx += 2;
        if (op != 2'd1) begin eb[idx] = td[d]; idx++; d++; end
        if (op == 2'd2) begin eb[idx] = td[d]; idx++; d++; end
      end
      size = idx;
    end else begin
      for (int i = 0; i < cnt && i < 5; i++) begin
        eb[2*i] = ta[i][7:0]; eb[2*i+1] = ta[i][15:8];
      end
      if (op == 2'd0) for (int i = 0; i < cnt && i < 5; i++) eb[2*cnt+i] = td[i];
      if (op == 2'd2) begin eb[2] = td[0]; eb[3] = td[1]; size = 4; end
      else size = (op == 2'd1) ? 2*cnt : 3*cnt;
    end
    legal = (cnt >= 1 && cnt <= 5 && op != 2'd3 && !(sp && op == 2'd2 && cnt != 1));
    nw = (size + 3) / 4;
    if (!legal) exp_code = 3;
    else if (bn > LIMIT) exp_code = 1;
    else if (eb_in) exp_code = 2;
    else exp_code = 0;
    exp_reads = !legal ? 0 : (bn > LIMIT ? LIMIT + 1 : bn + 1);
    exp_data = '0;
    if (exp_code == 0 && op == 2'd1)
      for (int n = 0; n < cnt; n++) exp_data[n*8 +: 8] = sp ? rb[n] : rb[2+3*n];

    @(negedge clk) model_clr = 1'b1;
    @(negedge clk) model_clr = 1'b0;
    req_op = op; req_split = sp; req_count = 3'(cnt);
    for (int i = 0; i < 5; i++) req_addr[i*16 +: 16] = ta[i];
    for (int i = 0; i < 10; i++) req_data[i*8 +: 8] = td[i];
    chk(req_ready == 1'b1, "R11", "ready before request", req_ready, 1);
    req_valid = 1'b1;
    @(posedge clk);
    viol = 0; got = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (rsp_valid) begin got = 1; break; end
      if (req_ready) viol++;
      req_op = ~op; req_split = ~sp; req_count = ~req_count; req_addr = ~req_addr;
    end
    code_s = rsp_code; data_s = rsp_data;
    req_valid = 1'b0;
    chk(got, "R11", "response arrived", got, 1);
    chk(viol == 0, "R11", "ready low while busy", viol, 0);
    chk(code_s == 2'(exp_code), exp_code == 3 ? "R1" : exp_code == 1 ? "R7" : "R9",
        "result code", code_s, exp_code);
    chk(data_s == exp_data, "R10", "response data", data_s, exp_data);
    chk(stat_reads == exp_reads, legal ? "R7" : "R1", "status reads", stat_reads, exp_reads);
    chk(rb_reads == ((exp_code == 0 && op == 2'd1) ? 4 : 0), "R10", "read-buffer reads",
        rb_reads, (exp_code == 0 && op == 2'd1) ? 4 : 0);
    if (!legal) begin
      chk(cmd_writes == 0 && buf_writes == 0, "R1", "no mailbox writes",
          cmd_writes + buf_writes, 0);
    end else begin
      chk(cmd_writes == 1, "R5", "command writes", cmd_writes, 1);
      chk(cmd_word == ((32'(size) << 16) | (32'(op) << 12) | 32'hFF), "R5", "command word",
          cmd_word, (32'(size) << 16) | (32'(op) << 12) | 32'hFF);
      chk(buf_writes == nw && wr_after_cmd == 0, "R4", "payload write count/order",
          buf_writes, nw);
      for (int w = 0; w < 5; w++) begin
        logic [31:0] ew;
        ew = (w < nw) ? {eb[4*w+3], eb[4*w+2], eb[4*w+1], eb[4*w]} : (32'hA5A5_0000 | w);
        chk(wimg[w] == ew, sp ? "R3" : "R2", "payload word", wimg[w], ew);
      end
      for (int k = 1; k < stat_reads && k < 8; k++)
        chk(stamp[k] - stamp[k-1] == GAP + 2, "R6", "poll spacing",
            stamp[k] - stamp[k-1], GAP + 2);
    end
    @(negedge clk);
    chk(acc_cnt == 1, "R11", "acceptances", acc_cnt, 1);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R11", "back to idle",
        {req_ready, rsp_valid}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0 || req_ready == 1'b1, "R12", "ready known in reset", req_ready, 1);
    rst_n = 1'b1;
    model_clr = 1'b1;
    @(negedge clk) model_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R12", "ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R12", "no response after reset", rsp_valid, 0);
    chk(cmd_writes == 0 && buf_writes == 0 && stat_reads == 0, "R12", "no bus traffic",
        cmd_writes + buf_writes + stat_reads, 0);
    // sweep of layout, operation and count
    for (int sp = 0; sp < 2; sp++)
      for (int op = 0; op < 4; op++)
        for (int c = 0; c < 7; c++)
          run(2'(op), c, 1'(sp), (c + op + sp) % 3, ((c + op) % 4) == 3);
    // R8: busy clears on the last permitted poll
    run(2'd1, 5, 1'b0, LIMIT, 1'b0);
    run(2'd1, 4, 1'b1, LIMIT, 1'b0);
    // R8 with R9: last poll clears busy and reports error
    run(2'd2, 1, 1'b0, LIMIT, 1'b1);
    // R7 with R9: error bit ignored while busy at the limit
    run(2'd0, 2, 1'b1, LIMIT + 1, 1'b1);
    run(2'd1, 3, 1'b1, 30, 1'b0);
    run(2'd2, 5, 1'b0, 9, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule